// File: doc/BRIEF.md
# Buck Converter Light-Load Mode Controller

This block is the digital state machine that decides how a synchronous step-down converter switches. It chooses between fixed-frequency PWM and a pulse-frequency burst mode for light loads. In PWM it only forwards an external duty request to the high-side and low-side gate requests. It leaves PWM once comparator flags have shown a light load on 32 clock edges in a row. In the burst mode it runs its own hysteresis loop from the output-voltage comparators: it charges, drains the inductor, then sleeps.

All pins are plain level signals sampled on the rising clock edge. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. The mode and sleep outputs decode the state register directly. Both gate requests come from one more register stage, which keeps them from ever overlapping. Each gate request therefore changes one clock after the state that calls for it. A change of side passes through one extra cycle with both requests low.

Top module: `buck_mode_ctl`

## Requirements
- R1: While `rst_n` is low, `mode_pfm`, `sleep`, `hs_req` and `ls_req` are all 0, and the block leaves reset in PWM with its qualification count at zero.
- R2: In PWM, `hs_req` follows `duty_req`=1 and `ls_req` follows `duty_req`=0. Each is delayed by one register, plus one both-off cycle when the active side changes.
- R3: `hs_req` and `ls_req` are never high together. A request on one side is always followed by at least one cycle in which the other side stays low.
- R4: PWM changes to burst mode (`mode_pfm`=1) on the 32nd consecutive rising edge at which `zero_cur` or `peak_below_mode` is high. A single edge with both flags low restarts the count.
- R5: While `force_pwm` is 1, the block never enters burst mode, and it returns from burst mode to PWM on the next edge. After release, a fresh run of 32 qualifying edges is needed.
- R6: In burst mode, a sleeping block (`sleep`=1) starts a charge phase when `vout_below_lo` is 1. The charge phase raises `hs_req` and ends when `vout_above_hi` or `peak_at_limit` is 1.
- R7: After a charge phase, and on entry to burst mode, the block drains with `ls_req` until `zero_cur` is 1. It then charges again if `vout_above_hi` is 0, and goes to sleep if it is 1.
- R8: During sleep, `sleep` is 1 and both gate requests are 0 from the second sleep cycle on. Sleep lasts until `vout_below_lo` or an exit condition.
- R9: `vout_below_lo2`=1 in any burst-mode state returns the block to PWM on the next edge. This exit takes priority over starting a charge phase.
- R10: Any mode change clears the qualification count, so after a return to PWM a full new run of 32 qualifying edges is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_pwm | input | 1 | Configuration bit pinning the block to PWM |
| duty_req | input | 1 | PWM duty request: 1 = high side, 0 = low side |
| zero_cur | input | 1 | Inductor current has reached zero |
| peak_below_mode | input | 1 | Peak high-side current below the mode-change level |
| peak_at_limit | input | 1 | Peak current has reached the burst-mode limit |
| vout_above_hi | input | 1 | Output above the upper burst threshold |
| vout_below_lo | input | 1 | Output below the lower burst threshold |
| vout_below_lo2 | input | 1 | Output below the burst-exit threshold |
| mode_pfm | output | 1 | 1 = burst mode, 0 = PWM |
| hs_req | output | 1 | High-side gate request |
| ls_req | output | 1 | Low-side gate request |
| sleep | output | 1 | Burst-mode sleep with both switches off |

## Verification
The bench breaks a light-load run after 20 edges and then counts the new run edge by edge. A design that kept its count, or was off by one, would change `mode_pfm` one or many cycles too early. It drives every side-to-side handover and checks the both-off cycle, which a design without the interlock would skip by driving the new side at once. It raises the exit comparator together with the sleep-wake comparator, so a design with the wrong priority would begin a charge phase instead of returning to PWM. It also returns to PWM with light load still present, which catches a count that was not cleared on the mode change.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;
  typedef enum logic [1:0] {
    ST_PWM   = 2'd0,
    ST_HS    = 2'd1,
    ST_LS    = 2'd2,
    ST_SLEEP = 2'd3
  } mc_state_t;
endpackage

// File: rtl/mc_light_qual.sv
module mc_light_qual #(
  parameter int unsigned QUAL_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic light,
  output logic hit
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign hit = enable && light && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!enable || !light || hit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0));
endmodule

// File: rtl/mc_mode_fsm.sv
module mc_mode_fsm
  import mode_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      force_pwm,
  input  logic      qual_hit,
  input  logic      duty_req,
  input  logic      zero_cur,
  input  logic      peak_at_limit,
  input  logic      above_hi,
  input  logic      below_lo,
  input  logic      below_lo2,
  output mc_state_t state,
  output logic      hs_want,
  output logic      ls_want
);
  mc_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_PWM:   if (qual_hit) nxt = ST_LS;
      ST_HS:    if (above_hi || peak_at_limit) nxt = ST_LS;
      ST_LS:    if (zero_cur) nxt = above_hi ? ST_SLEEP : ST_HS;
      ST_SLEEP: if (below_lo) nxt = ST_HS;
      default:  nxt = ST_PWM;
    endcase
    if (state != ST_PWM && (force_pwm || below_lo2)) nxt = ST_PWM;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_PWM;
    else        state <= nxt;
  end

  always_comb begin
    hs_want = 1'b0;
    ls_want = 1'b0;
    unique case (state)
      ST_PWM: begin
        hs_want = duty_req;
        ls_want = !duty_req;
      end
      ST_HS:    hs_want = 1'b1;
      ST_LS:    ls_want = 1'b1;
      default: begin
        hs_want = 1'b0;
        ls_want = 1'b0;
      end
    endcase
  end

  // R6
  wake_to_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && below_lo && !below_lo2 && !force_pwm) |=> (state == ST_HS));

  // R7
  drain_recharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LS && zero_cur && !above_hi && !below_lo2 && !force_pwm) |=> (state == ST_HS));
endmodule

// File: rtl/mc_gate_stage.sv
module mc_gate_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_want,
  input  logic ls_want,
  output logic hs_q,
  output logic ls_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= hs_want && !ls_q;
      ls_q <= ls_want && !hs_q;
    end
  end

  // R3
  hs_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_q |=> !ls_q);

  // R3
  ls_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_q |=> !hs_q);
endmodule

// File: rtl/buck_mode_ctl.sv
module buck_mode_ctl
  import mode_ctl_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_pwm,
  input  logic duty_req,
  input  logic zero_cur,
  input  logic peak_below_mode,
  input  logic peak_at_limit,
  input  logic vout_above_hi,
  input  logic vout_below_lo,
  input  logic vout_below_lo2,
  output logic mode_pfm,
  output logic hs_req,
  output logic ls_req,
  output logic sleep
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(QUAL_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  mc_state_t state;
  logic      qual_hit;
  logic      hs_want;
  logic      ls_want;
  logic      light;

  assign light = zero_cur || peak_below_mode;

  mc_light_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable ((state == ST_PWM) && !force_pwm),
    .light  (light),
    .hit    (qual_hit)
  );

  mc_mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .force_pwm     (force_pwm),
    .qual_hit      (qual_hit),
    .duty_req      (duty_req),
    .zero_cur      (zero_cur),
    .peak_at_limit (peak_at_limit),
    .above_hi      (vout_above_hi),
    .below_lo      (vout_below_lo),
    .below_lo2     (vout_below_lo2),
    .state         (state),
    .hs_want       (hs_want),
    .ls_want       (ls_want)
  );

  mc_gate_stage u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_want (hs_want),
    .ls_want (ls_want),
    .hs_q    (hs_req),
    .ls_q    (ls_req)
  );

  assign mode_pfm = (state != ST_PWM);
  assign sleep    = (state == ST_SLEEP);

  // Independent run-length tracker for the entry check below
  logic [CW-1:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n)                             run_len <= '0;
    else if (!light || mode_pfm || force_pwm) run_len <= '0;
    else if (run_len != FULL)               run_len <= run_len + 1'b1;
  end

  // R4 R10
  entry_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_pfm) |-> ($past(run_len) >= LAST));

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_req && ls_req));

  // R5
  force_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_pwm |=> !mode_pfm);

  // R9
  low2_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pfm && vout_below_lo2) |=> !mode_pfm);

  // R8
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && $past(sleep)) |-> (!hs_req && !ls_req));
endmodule

// File: tb/test_buck_mode_ctl.sv
module test_buck_mode_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic force_pwm = 1'b0, duty_req = 1'b0, zero_cur = 1'b0, peak_below_mode = 1'b0;
  logic peak_at_limit = 1'b0, vout_above_hi = 1'b0, vout_below_lo = 1'b0, vout_below_lo2 = 1'b0;
  logic mode_pfm, hs_req, ls_req, sleep;

  always #4 clk = ~clk;

  buck_mode_ctl i_buck_mode_ctl (
    .clk(clk), .rst_n(rst_n), .force_pwm(force_pwm), .duty_req(duty_req),
    .zero_cur(zero_cur), .peak_below_mode(peak_below_mode), .peak_at_limit(peak_at_limit),
    .vout_above_hi(vout_above_hi), .vout_below_lo(vout_below_lo),
    .vout_below_lo2(vout_below_lo2), .mode_pfm(mode_pfm), .hs_req(hs_req),
    .ls_req(ls_req), .sleep(sleep)
  );

  // item bits: {mode_pfm, sleep, hs_req, ls_req}
  typedef struct {
    int       due;
    string    tag;
    logic [3:0] val;
    logic [3:0] msk;
  } exp_t;

  localparam logic [3:0] M_MODE = 4'b1100;
  localparam logic [3:0] M_GATE = 4'b0011;
  localparam logic [3:0] M_ALL  = 4'b1111;

  exp_t q[$];
  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  task automatic expect_at(int dly, string tag, logic [3:0] val, logic [3:0] msk);
    exp_t e;
    e.due = cyc + dly;
    e.tag = tag;
    e.val = val;
    e.msk = msk;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares every queued item on its due cycle
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due <= cyc) begin
          logic [3:0] got;
          got = {mode_pfm, sleep, hs_req, ls_req};
          n_run++;
          if (q[i].due < cyc || ((got & q[i].msk) != (q[i].val & q[i].msk))) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (mask %b) at cycle %0d",
                     q[i].tag, got, q[i].val, q[i].msk, cyc);
          end
          q.delete(i);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // Driver
  initial begin
    tick(3);
    expect_at(1, "R1 reset outputs", 4'b0000, M_ALL);
    tick(2);
    rst_n = 1'b1;
    tick(3);

    // R2 / R3: PWM duty pass-through with dead cycle
    duty_req = 1'b1;
    expect_at(1, "R3 gap hs handover", 4'b0000, M_ALL);
    expect_at(2, "R2 duty high to hs", 4'b0010, M_ALL);
    tick(4);
    duty_req = 1'b0;
    expect_at(1, "R3 gap ls handover", 4'b0000, M_GATE);
    expect_at(2, "R2 duty low to ls", 4'b0001, M_GATE);
    tick(4);

    // R4: interrupted run restarts the count
    peak_below_mode = 1'b1;
    tick(20);
    peak_below_mode = 1'b0;
    tick(1);
    peak_below_mode = 1'b1;
    expect_at(31, "R4 still PWM at edge 31", 4'b0000, M_MODE);
    expect_at(32, "R4 entry at edge 32", 4'b1000, M_MODE);
    tick(32);
    peak_below_mode = 1'b0;
    expect_at(1, "R7 entry drains with ls", 4'b1001, M_ALL);
    tick(2);

    // R8: drained and above high threshold -> sleep
    zero_cur = 1'b1; vout_above_hi = 1'b1;
    expect_at(1, "R8 sleep entered", 4'b1100, M_MODE);
    expect_at(2, "R8 gates off in sleep", 4'b0000, M_GATE);
    tick(2);
    zero_cur = 1'b0; vout_above_hi = 1'b0;
    expect_at(3, "R8 sleep held", 4'b1100, M_ALL);
    tick(5);

    // R6: wake and charge
    vout_below_lo = 1'b1;
    expect_at(1, "R6 wake leaves sleep", 4'b1000, M_MODE);
    expect_at(2, "R6 hs on in charge", 4'b0010, M_GATE);
    tick(1);
    vout_below_lo = 1'b0;
    expect_at(3, "R6 hs held below high", 4'b1010, M_ALL);
    tick(5);

    // R6 / R3: peak limit ends charge, gap, then drain
    peak_at_limit = 1'b1;
    expect_at(2, "R3 gap hs to ls", 4'b0000, M_GATE);
    expect_at(3, "R7 ls drain after limit", 4'b1001, M_ALL);
    tick(1);
    peak_at_limit = 1'b0;
    tick(3);

    // R7: zero current while below high -> charge again
    zero_cur = 1'b1;
    expect_at(2, "R3 gap ls to hs", 4'b0000, M_GATE);
    expect_at(3, "R7 recharge", 4'b1010, M_ALL);
    tick(1);
    zero_cur = 1'b0;
    tick(3);

    // R6: above high ends charge
    vout_above_hi = 1'b1;
    expect_at(3, "R6 charge ends on high", 4'b1001, M_ALL);
    tick(4);
    zero_cur = 1'b1;
    expect_at(1, "R7 drain to sleep", 4'b1100, M_MODE);
    tick(1);
    zero_cur = 1'b0; vout_above_hi = 1'b0;
    peak_below_mode = 1'b1;
    tick(5);

    // R9: low2 exit wins over wake
    vout_below_lo2 = 1'b1; vout_below_lo = 1'b1;
    expect_at(1, "R9 low2 exit to PWM", 4'b0000, M_MODE);
    tick(1);
    vout_below_lo2 = 1'b0; vout_below_lo = 1'b0;

    // R10: count restarted after the mode change
    expect_at(31, "R10 no early re-entry", 4'b0000, M_MODE);
    expect_at(32, "R10 re-entry after full run", 4'b1000, M_MODE);
    tick(33);

    // R5: force exits and blocks
    force_pwm = 1'b1;
    expect_at(1, "R5 force exits burst", 4'b0000, M_MODE);
    expect_at(40, "R5 force blocks entry", 4'b0000, M_MODE);
    tick(41);
    force_pwm = 1'b0;
    peak_below_mode = 1'b0;
    zero_cur = 1'b1;
    expect_at(31, "R4 zero-current run edge 31", 4'b0000, M_MODE);
    expect_at(32, "R4 zero-current entry", 4'b1000, M_MODE);
    tick(34);
    zero_cur = 1'b0;
    tick(3);

    if (q.size() != 0) begin
      n_fail += q.size();
      n_run  += q.size();
      $display("FAIL scoreboard: got %0d pending expected 0", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule